// File: doc/BRIEF.md
# Clock policy controller

This block decides, for a bank of clocks, which ones are allowed to run under the power policy currently in force. It keeps one enable mask per policy. Each clock owns the same bit position in every mask. A power-management input names the active policy, and the block drives a registered enable vector with one bit per clock. Gating cells, dividers and the logic that picks the policy sit outside the block.

Software reaches the block over a simple synchronous register bus that completes one access per cycle. The bus has a byte address, write data, a write strobe and combinational read data. Every register except the key register is write-protected until the correct key has been written there. The masks are frozen while the policy engine runs. To change them, software first halts the engine, then rewrites the masks, then restarts the engine with a start command that carries one of two mode bits. While the engine is halted, the enable vector keeps its last value.

Register words, at byte address = 4 × word: word 0 key/lock, word 1 halt, word 2 start command, word 3 error, words 4 to 7 the masks for policies 0 to 3.

Top module: `clkpol_ctrl`

## Requirements
- R1: After reset the block is locked and the engine is running. The error flag is 0, every mask reads 0xFFFFFFFF, and clk_en_o is all ones.
- R2: Writing 0xA5A50001 to byte address 0x00 unlocks the block. Any other value written there locks it. Reading address 0x00 returns the lock state in bit 0 (1 = unlocked).
- R3: While the block is locked, writes to every address other than 0x00 change nothing. This includes the halt state, the masks and the error flag.
- R4: An unlocked write to 0x04 with bit 0 set halts the engine. Reading 0x04 returns 1 in bit 0 while the engine is halted and 0 while it runs.
- R5: An unlocked write to 0x10 + 4·p while the engine is halted stores the data as the mask for policy p. The mask reads back at the same address.
- R6: An unlocked mask write while the engine runs leaves the mask unchanged and sets a sticky error flag, which reads as bit 0 of 0x0C. An unlocked write of 1 to bit 0 of 0x0C clears the flag.
- R7: An unlocked write to 0x08 restarts a halted engine only when it sets bit 0 (start) together with bit 1 or bit 2 (the two restart modes). A write with start alone, or with a mode bit but no start, leaves the engine halted.
- R8: While the engine runs, clk_en_o at each clock edge takes the mask of the policy that policy_i named just before that edge.
- R9: While the engine is halted, clk_en_o holds its value, whatever policy_i or the masks do.
- R10: After the edge that restarts the engine, clk_en_o takes the updated mask of the current policy at the following edge.
- R11: Addresses that are unaligned (nonzero low two bits) or unmapped read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe; when low the access is a read |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| policy_i | input | 2 | Index of the policy currently in force |
| clk_en_o | output | 32 | Per-clock enable under the active policy |

## Verification
The restart command and a change of policy can land in the same cycle. That cycle decides whether the first enable vector after the restart comes from the old policy or the new one. The bench provokes this by setting policy_i to a freshly rewritten policy on the very cycle it issues the start-plus-mode write. It then expects that policy's new mask exactly one edge after the restart edge. A behavioural model, updated on every edge from the same inputs, gives the expected enable vector each cycle, so a stale or early update is caught in the cycle it occurs.

// File: rtl/clkpol_pkg.sv
package clkpol_pkg;
    localparam logic [31:0] ACCESS_KEY_DEF = 32'hA5A5_0001;
    // register word indices (byte address = 4 * word)
    localparam int W_ACCESS = 0;
    localparam int W_HALT   = 1;
    localparam int W_CTRL   = 2;
    localparam int W_ERR    = 3;
    localparam int W_MASK0  = 4;
    // start-command bits
    localparam int B_GO     = 0;
    localparam int B_MODE_A = 1;
    localparam int B_MODE_B = 2;

    typedef struct packed {
        logic run;
        logic err;
    } eng_state_t;
endpackage

// File: rtl/clkpol_access.sv
module clkpol_access #(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = clkpol_pkg::ACCESS_KEY_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              unlocked_o
);
    typedef struct packed {
        logic unlocked;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr_i) begin
            st_d.unlocked = (wdata_i == KEY[DATA_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked_o = st_q.unlocked;
endmodule

// File: rtl/clkpol_engine.sv
module clkpol_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_wr_i,
    input  logic       ctrl_wr_i,
    input  logic [2:0] ctrl_bits_i,
    input  logic       mask_try_i,
    input  logic       err_clr_i,
    output logic       run_o,
    output logic       err_o
);
    import clkpol_pkg::*;

    eng_state_t st_d, st_q;
    logic       restart_ok;

    assign restart_ok = ctrl_wr_i && ctrl_bits_i[B_GO]
                        && (ctrl_bits_i[B_MODE_A] || ctrl_bits_i[B_MODE_B]);

    always_comb begin
        st_d = st_q;
        if (halt_wr_i) begin
            st_d.run = 1'b0;
        end else if (restart_ok && !st_q.run) begin
            st_d.run = 1'b1;
        end
        if (mask_try_i && st_q.run) begin
            st_d.err = 1'b1;
        end else if (err_clr_i) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b1, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o = st_q.run;
    assign err_o = st_q.err;
endmodule

// File: rtl/clkpol_maskbank.sv
module clkpol_maskbank #(
    parameter int NPOL = 4,
    parameter int NCLK = 32,
    localparam int PW  = (NPOL > 1) ? $clog2(NPOL) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic [PW-1:0]             sel_i,
    input  logic [NCLK-1:0]           wdata_i,
    input  logic                      run_i,
    output logic [NPOL-1:0][NCLK-1:0] masks_o
);
    for (genvar p = 0; p < NPOL; p++) begin : g_pol
        typedef struct packed {
            logic [NCLK-1:0] bits;
        } ent_t;

        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_i && !run_i && (sel_i == PW'(p))) begin
                ent_d.bits = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '{bits: '1};
            end else begin
                ent_q <= ent_d;
            end
        end

        assign masks_o[p] = ent_q.bits;
    end
endmodule

// File: rtl/clkpol_outsel.sv
module clkpol_outsel #(
    parameter int NPOL = 4,
    parameter int NCLK = 32,
    localparam int PW  = (NPOL > 1) ? $clog2(NPOL) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_i,
    input  logic [PW-1:0]             policy_i,
    input  logic [NPOL-1:0][NCLK-1:0] masks_i,
    output logic [NCLK-1:0]           en_o
);
    typedef struct packed {
        logic [NCLK-1:0] en;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            st_d.en = masks_i[policy_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/clkpol_ctrl.sv
// NPOL must be a power of two; the masks occupy an NPOL-aligned block of words.
module clkpol_ctrl #(
    parameter int          ADDR_W = 8,
    parameter int          NPOL   = 4,
    parameter int          NCLK   = 32,
    parameter logic [31:0] KEY    = clkpol_pkg::ACCESS_KEY_DEF,
    localparam int         PW     = (NPOL > 1) ? $clog2(NPOL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              wr_i,
    output logic [31:0]       rdata_o,
    input  logic [PW-1:0]     policy_i,
    output logic [NCLK-1:0]   clk_en_o
);
    import clkpol_pkg::*;

    localparam int DATA_W   = 32;
    localparam int WORD_W   = ADDR_W - 2;
    localparam int MASK_BLK = (W_MASK0 + NPOL - 1) / NPOL;

    logic [WORD_W-1:0]          word;
    logic                       aligned;
    logic                       hit_access, hit_halt, hit_ctrl, hit_err, hit_mask;
    logic                       wr_ok;
    logic                       unlocked_w, run_w, err_w;
    logic [NPOL-1:0][NCLK-1:0]  masks_w;
    logic [PW-1:0]              mask_sel;

    assign word       = addr_i[ADDR_W-1:2];
    assign aligned    = (addr_i[1:0] == 2'b00);
    assign hit_access = aligned && (word == WORD_W'(W_ACCESS));
    assign hit_halt   = aligned && (word == WORD_W'(W_HALT));
    assign hit_ctrl   = aligned && (word == WORD_W'(W_CTRL));
    assign hit_err    = aligned && (word == WORD_W'(W_ERR));
    assign hit_mask   = aligned && (word[WORD_W-1:PW] == (WORD_W-PW)'(MASK_BLK));
    assign mask_sel   = word[PW-1:0];
    assign wr_ok      = wr_i && unlocked_w;

    clkpol_access #(.DATA_W(DATA_W), .KEY(KEY)) u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (wr_i && hit_access),
        .wdata_i    (wdata_i),
        .unlocked_o (unlocked_w)
    );

    clkpol_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_wr_i   (wr_ok && hit_halt && wdata_i[0]),
        .ctrl_wr_i   (wr_ok && hit_ctrl),
        .ctrl_bits_i (wdata_i[2:0]),
        .mask_try_i  (wr_ok && hit_mask),
        .err_clr_i   (wr_ok && hit_err && wdata_i[0]),
        .run_o       (run_w),
        .err_o       (err_w)
    );

    clkpol_maskbank #(.NPOL(NPOL), .NCLK(NCLK)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ok && hit_mask),
        .sel_i   (mask_sel),
        .wdata_i (wdata_i[NCLK-1:0]),
        .run_i   (run_w),
        .masks_o (masks_w)
    );

    clkpol_outsel #(.NPOL(NPOL), .NCLK(NCLK)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_w),
        .policy_i (policy_i),
        .masks_i  (masks_w),
        .en_o     (clk_en_o)
    );

    always_comb begin
        rdata_o = '0;
        if (hit_access) begin
            rdata_o[0] = unlocked_w;
        end else if (hit_halt) begin
            rdata_o[0] = !run_w;
        end else if (hit_err) begin
            rdata_o[0] = err_w;
        end else if (hit_mask) begin
            rdata_o[NCLK-1:0] = masks_w[mask_sel];
        end
    end
endmodule

// File: rtl/clkpol_chk.sv
module clkpol_chk #(
    parameter int          ADDR_W = 8,
    parameter int          NPOL   = 4,
    parameter int          NCLK   = 32,
    parameter logic [31:0] KEY    = 32'hA5A5_0001,
    localparam int         PW     = (NPOL > 1) ? $clog2(NPOL) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr_i,
    input logic [31:0]               wdata_i,
    input logic                      wr_i,
    input logic [PW-1:0]             policy_i,
    input logic [NCLK-1:0]           clk_en_o,
    input logic                      unlocked,
    input logic                      run,
    input logic                      err,
    input logic [NPOL-1:0][NCLK-1:0] masks
);
    logic            key_slot, ctrl_slot, mask_slot;
    logic [NCLK-1:0] chosen;

    assign key_slot  = (addr_i == '0);
    assign ctrl_slot = (addr_i == ADDR_W'(8));
    assign mask_slot = (addr_i[1:0] == 2'b00) && (addr_i >= ADDR_W'(16))
                       && (addr_i < ADDR_W'(16 + 4 * NPOL));
    assign chosen    = masks[policy_i];

    a_r2_key_decides_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && key_slot) |=> (unlocked == $past(wdata_i == KEY)));

    a_r3_locked_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !unlocked && !key_slot) |=> ($stable(run) && $stable(err) && $stable(masks)));

    a_r6_running_mask_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && unlocked && mask_slot && run) |=> (err && $stable(masks)));

    a_r7_start_without_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && unlocked && ctrl_slot && !run && !wdata_i[1] && !wdata_i[2]) |=> !run);

    a_r8_follow_policy: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (clk_en_o == $past(chosen)));

    a_r9_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(clk_en_o));
endmodule

bind clkpol_ctrl clkpol_chk #(.ADDR_W(ADDR_W), .NPOL(NPOL), .NCLK(NCLK), .KEY(KEY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_i     (wr_i),
    .policy_i (policy_i),
    .clk_en_o (clk_en_o),
    .unlocked (unlocked_w),
    .run      (run_w),
    .err      (err_w),
    .masks    (masks_w)
);

// File: tb/tb_clkpol_ctrl.sv
module tb_clkpol_ctrl;
    localparam logic [31:0] KEY = 32'hA5A5_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  policy = '0;
    logic [31:0] en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit          m_unl;
    bit          m_run;
    bit          m_err;
    logic [31:0] m_mask [4];
    logic [31:0] m_out;

    always #2 clk = ~clk;

    clkpol_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .wr_i     (wr),
        .rdata_o  (rdata),
        .policy_i (policy),
        .clk_en_o (en)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_unl = 0; m_run = 1; m_err = 0; m_out = '1;
            foreach (m_mask[i]) m_mask[i] = '1;
        end else begin
            logic [31:0] nxt;
            nxt = m_run ? m_mask[policy] : m_out;
            if (wr && addr[1:0] == 2'b00) begin
                int wi;
                wi = int'(addr >> 2);
                if (wi == 0) m_unl = (wdata == KEY);
                else if (m_unl) begin
                    if (wi == 1 && wdata[0]) m_run = 0;
                    else if (wi == 2 && wdata[0] && (wdata[1] || wdata[2])) m_run = 1;
                    else if (wi == 3 && wdata[0]) m_err = 0;
                    else if (wi >= 4 && wi <= 7) begin
                        if (m_run) m_err = 1;
                        else m_mask[wi-4] = wdata;
                    end
                end
            end
            m_out = nxt;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        int wi;
        if (a[1:0] != 2'b00) return '0;
        wi = int'(a >> 2);
        case (wi)
            0: return {31'b0, m_unl};
            1: return {31'b0, !m_run};
            3: return {31'b0, m_err};
            4, 5, 6, 7: return m_mask[wi-4];
            default: return '0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R8 R9 R10: enable vector against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) check("R8/R9/R10 per-cycle clk_en_o", en, m_out);
    end

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    // read: compare against both the model and a value derived from the requirement
    task automatic rd_reg(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a; wr = 1'b0;
        #1;
        check(req, rdata, exp);
        check({req, " model"}, rdata, m_read(a));
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg("R1 lock", 8'h00, 32'h0);
        rd_reg("R1 halt", 8'h04, 32'h0);
        rd_reg("R1 err", 8'h0C, 32'h0);
        for (int p = 0; p < 4; p++) rd_reg("R1 mask", 8'(16 + 4 * p), 32'hFFFF_FFFF);
        check("R1 clk_en_o", en, 32'hFFFF_FFFF);

        // R3 locked writes ignored
        wr_reg(8'h04, 32'h1);
        rd_reg("R3 halt while locked", 8'h04, 32'h0);
        wr_reg(8'h10, 32'h0000_1234);
        rd_reg("R3 mask while locked", 8'h10, 32'hFFFF_FFFF);
        rd_reg("R3 err while locked", 8'h0C, 32'h0);

        // R2 key handling
        wr_reg(8'h00, 32'hA5A5_0002);
        rd_reg("R2 wrong key", 8'h00, 32'h0);
        wr_reg(8'h00, KEY);
        rd_reg("R2 right key", 8'h00, 32'h1);

        // R6 mask write while running
        wr_reg(8'h14, 32'h0);
        rd_reg("R6 mask unchanged", 8'h14, 32'hFFFF_FFFF);
        rd_reg("R6 err set", 8'h0C, 32'h1);
        wr_reg(8'h0C, 32'h1);
        rd_reg("R6 err cleared", 8'h0C, 32'h0);

        // R4 halt, R5 mask update, R9 hold
        wr_reg(8'h04, 32'h1);
        rd_reg("R4 halted", 8'h04, 32'h1);
        held = en;
        policy = 2'd3;
        for (int p = 0; p < 4; p++) wr_reg(8'(16 + 4 * p), 32'h0F0F_0000 | 32'(p * 17 + 1));
        for (int p = 0; p < 4; p++) rd_reg("R5 mask readback", 8'(16 + 4 * p), 32'h0F0F_0000 | 32'(p * 17 + 1));
        check("R9 held while halted", en, held);

        // R7 invalid restarts
        wr_reg(8'h08, 32'h1);
        rd_reg("R7 start alone", 8'h04, 32'h1);
        wr_reg(8'h08, 32'h6);
        rd_reg("R7 mode without start", 8'h04, 32'h1);
        check("R9 held after bad starts", en, held);

        // R7 + R10 valid restart
        policy = 2'd1;
        wr_reg(8'h08, 32'h3);
        @(negedge clk);
        check("R10 first vector after restart", en, 32'h0F0F_0012);
        rd_reg("R7 running", 8'h04, 32'h0);

        // R8 policy switching
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            policy = 2'(p);
            @(negedge clk);
            check("R8 policy switch", en, 32'h0F0F_0000 | 32'(p * 17 + 1));
        end

        // R10 restart and policy change in the same cycle
        wr_reg(8'h04, 32'h1);
        wr_reg(8'h18, 32'hDEAD_0000);
        @(negedge clk);
        addr = 8'h08; wdata = 32'h5; wr = 1'b1; policy = 2'd2;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        check("R10 same-cycle restart and switch", en, 32'hDEAD_0000);

        // R11 unaligned / unmapped
        rd_reg("R11 unmapped read", 8'h40, 32'h0);
        rd_reg("R11 unaligned read", 8'h12, 32'h0);
        wr_reg(8'h05, 32'h1);
        rd_reg("R11 unaligned halt write", 8'h04, 32'h0);

        // R2 relock then R3 and R11
        wr_reg(8'h00, 32'h0);
        rd_reg("R2 relocked", 8'h00, 32'h0);
        wr_reg(8'h04, 32'h1);
        rd_reg("R3 halt after relock", 8'h04, 32'h0);
        wr_reg(8'h01, KEY);
        rd_reg("R11 unaligned key write", 8'h00, 32'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule